// File: doc/BRIEF.md
# Bidirectional Mailbox Slave Port

This block lets an external master processor and a local processor pass bytes to each other through two banks of mailbox registers, one bank per direction, each holding three 8-bit registers. The master reaches the block over an asynchronous parallel bus: a chip select, a 2-bit register address, separate read and write strobes, an 8-bit input bus and an 8-bit output bus. The local processor uses a single-cycle synchronous register bus.

The master's strobes are brought into the local clock domain by a synchroniser, and an access takes effect on the strobe's rising edge. Register 0 of each bank is the doorbell. Writing it marks that direction full and interrupts the receiver. When the receiver reads it, the flag and the interrupt are released. Registers 1 and 2 carry extra payload and have no side effects. Address 3 on either side returns a status byte holding both full flags.

Top module: `mbox_slave_port`

## Requirements
- R1: After reset, all six mailbox registers read 0x00, both full flags are clear, and `mIrq` and `lIrq` are low.
- R2: A master write (chip select high when the synchronised write strobe rises) to address 0, 1 or 2 stores `mDataIn` in the master-to-local register of that address. The register changes on the third rising clock edge after `mWr` goes high, and the local side reads it back on `lRdata` at the same address.
- R3: A master write to address 0 sets the master-to-local full flag, which drives `lIrq` high.
- R4: A local read (`lSel` high, `lWr` low) of address 0 clears the master-to-local full flag, so `lIrq` is low after that clock edge.
- R5: A local write (`lSel` and `lWr` high) to address 0, 1 or 2 stores `lWdata` in the local-to-master register of that address, visible on `mDataOut` right after the edge. A local write to address 0 also sets the local-to-master full flag, which drives `mIrq` high.
- R6: A master read of address 0 clears the local-to-master full flag, so `mIrq` is low from the third rising edge after `mRd` goes high.
- R7: Writes to or reads of addresses 1 and 2 never set or clear a full flag.
- R8: Address 3 reads as status on both sides: bit 0 is the master-to-local full flag, bit 1 is the local-to-master full flag, and bits 7:2 are 0. Writes to address 3 from either side change nothing.
- R9: A master strobe acts only once per rising edge, however long it is held high. A strobe edge seen while `mCs` is low has no effect.
- R10: If a master write to address 0 and a local read of address 0 take effect on the same clock edge, the new byte is stored and the full flag ends up set.
- R11: `mDataOut` always shows the local-to-master register, or the status, at `mAddr`. `lRdata` always shows the master-to-local register, or the status, at `lAddr`. Both paths are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mCs | input | 1 | Master chip select |
| mAddr | input | 2 | Master register address |
| mRd | input | 1 | Master read strobe, asynchronous, active high |
| mWr | input | 1 | Master write strobe, asynchronous, active high |
| mDataIn | input | 8 | Master write data |
| mDataOut | output | 8 | Master read data |
| mIrq | output | 1 | Interrupt to master: local-to-master mailbox full |
| lSel | input | 1 | Local bus access this cycle |
| lWr | input | 1 | Local access is a write when high |
| lAddr | input | 2 | Local register address |
| lWdata | input | 8 | Local write data |
| lRdata | output | 8 | Local read data |
| lIrq | output | 1 | Interrupt to local side: master-to-local mailbox full |

## Verification
The assertions check on every cycle that:
- a doorbell write raises the receiver's interrupt on the next cycle;
- a doorbell read drops it, unless a write to the same doorbell lands on the same edge;
- an interrupt never rises without a doorbell write;
- a held strobe never produces two access events in a row;
- the master's status byte always matches both interrupt lines.

Only the bench scenarios can show the rest:
- the exact three-edge latency of master accesses;
- that payload registers keep their contents through ignored accesses;
- that a deselected strobe is ignored;
- that the collision case ends with the new byte stored.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Qualified single-cycle access strobes from control to the datapath
  typedef struct packed {
    logic m2lWr;  // master write event, chip selected
    logic l2mRd;  // master read event, chip selected
    logic l2mWr;  // local write this cycle
    logic m2lRd;  // local read this cycle
  } mboxCtrlT;
endpackage

// File: rtl/mbox_strobe_sync.sv
module mbox_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic risePulse
);
  logic [STAGES-1:0] chain;
  logic lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      lastQ <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], asyncIn};
      lastQ <= chain[STAGES-1];
    end
  end

  assign risePulse = chain[STAGES-1] & ~lastQ;
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     mCs,
  input  logic     mRd,
  input  logic     mWr,
  input  logic     lSel,
  input  logic     lWr,
  output mboxCtrlT ctrl
);
  logic wrRise;
  logic rdRise;

  mbox_strobe_sync #(.STAGES(SYNC_STAGES)) u_wrSync (
    .clk(clk), .rstN(rstN), .asyncIn(mWr), .risePulse(wrRise)
  );
  mbox_strobe_sync #(.STAGES(SYNC_STAGES)) u_rdSync (
    .clk(clk), .rstN(rstN), .asyncIn(mRd), .risePulse(rdRise)
  );

  always_comb begin
    ctrl.m2lWr = wrRise & mCs;
    ctrl.l2mRd = rdRise & mCs;
    ctrl.l2mWr = lSel & lWr;
    ctrl.m2lRd = lSel & ~lWr;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REGS   = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxCtrlT          ctrl,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [DATA_W-1:0] mDataIn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] mDataOut,
  output logic [DATA_W-1:0] lRdata,
  output logic              m2lFull,
  output logic              l2mFull
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(REGS);
  localparam logic [ADDR_W-1:0] DOOR_ADDR   = '0;

  logic [DATA_W-1:0] m2lReg [REGS];
  logic [DATA_W-1:0] l2mReg [REGS];
  logic [DATA_W-1:0] statusByte;

  for (genvar i = 0; i < REGS; i++) begin : g_regs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) m2lReg[i] <= '0;
      else if (ctrl.m2lWr && mAddr == ADDR_W'(i)) m2lReg[i] <= mDataIn;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) l2mReg[i] <= '0;
      else if (ctrl.l2mWr && lAddr == ADDR_W'(i)) l2mReg[i] <= lWdata;
    end
  end

  // Doorbell flags: a set on the same edge as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m2lFull <= 1'b0;
      l2mFull <= 1'b0;
    end else begin
      if (ctrl.m2lWr && mAddr == DOOR_ADDR)      m2lFull <= 1'b1;
      else if (ctrl.m2lRd && lAddr == DOOR_ADDR) m2lFull <= 1'b0;
      if (ctrl.l2mWr && lAddr == DOOR_ADDR)      l2mFull <= 1'b1;
      else if (ctrl.l2mRd && mAddr == DOOR_ADDR) l2mFull <= 1'b0;
    end
  end

  assign statusByte = {{(DATA_W-2){1'b0}}, l2mFull, m2lFull};

  always_comb begin
    mDataOut = '0;
    lRdata   = '0;
    if (mAddr == STATUS_ADDR) mDataOut = statusByte;
    if (lAddr == STATUS_ADDR) lRdata   = statusByte;
    for (int i = 0; i < REGS; i++) begin
      if (mAddr == ADDR_W'(i)) mDataOut = l2mReg[i];
      if (lAddr == ADDR_W'(i)) lRdata   = m2lReg[i];
    end
  end
endmodule

// File: rtl/mbox_slave_port.sv
module mbox_slave_port
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REGS        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(REGS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mCs,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic              mRd,
  input  logic              mWr,
  input  logic [DATA_W-1:0] mDataIn,
  output logic [DATA_W-1:0] mDataOut,
  output logic              mIrq,
  input  logic              lSel,
  input  logic              lWr,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic              lIrq
);
  mboxCtrlT ctrl;
  logic m2lFull;
  logic l2mFull;

  mbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .mCs(mCs), .mRd(mRd), .mWr(mWr),
    .lSel(lSel), .lWr(lWr), .ctrl(ctrl)
  );

  mbox_datapath #(.DATA_W(DATA_W), .REGS(REGS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .mAddr(mAddr), .mDataIn(mDataIn), .lAddr(lAddr), .lWdata(lWdata),
    .mDataOut(mDataOut), .lRdata(lRdata),
    .m2lFull(m2lFull), .l2mFull(l2mFull)
  );

  assign lIrq = m2lFull;
  assign mIrq = l2mFull;
endmodule

// File: rtl/mbox_slave_port_chk.sv
module mbox_slave_port_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REGS   = 3,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input mboxCtrlT          ctrl,
  input logic [ADDR_W-1:0] mAddr,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lSel,
  input logic              lWr,
  input logic [DATA_W-1:0] mDataOut,
  input logic              mIrq,
  input logic              lIrq
);
  localparam logic [ADDR_W-1:0] STAT = ADDR_W'(REGS);
  logic mDoor;
  logic lDoorWr;
  logic lDoorRd;

  assign mDoor   = (mAddr == '0);
  assign lDoorWr = lSel && lWr && (lAddr == '0);
  assign lDoorRd = lSel && !lWr && (lAddr == '0);

  a_r3_master_door_raises_lirq: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.m2lWr && mDoor |=> lIrq);
  a_r4_local_read_drops_lirq: assert property (@(posedge clk) disable iff (!rstN)
    lDoorRd && !(ctrl.m2lWr && mDoor) |=> !lIrq);
  a_r5_local_door_raises_mirq: assert property (@(posedge clk) disable iff (!rstN)
    lDoorWr |=> mIrq);
  a_r6_master_read_drops_mirq: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.l2mRd && mDoor && !lDoorWr |=> !mIrq);
  a_r7_mirq_only_from_door: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mIrq) |-> $past(lDoorWr));
  a_r7_lirq_only_from_door: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lIrq) |-> $past(ctrl.m2lWr && mDoor));
  a_r8_status_matches_irqs: assert property (@(posedge clk) disable iff (!rstN)
    mAddr == STAT |-> mDataOut == {{(DATA_W-2){1'b0}}, mIrq, lIrq});
  a_r9_single_write_event: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.m2lWr |=> !ctrl.m2lWr);
  a_r9_single_read_event: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.l2mRd |=> !ctrl.l2mRd);
endmodule

bind mbox_slave_port mbox_slave_port_chk #(
  .DATA_W(DATA_W), .REGS(REGS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .ctrl(ctrl), .mAddr(mAddr), .lAddr(lAddr),
  .lSel(lSel), .lWr(lWr), .mDataOut(mDataOut), .mIrq(mIrq), .lIrq(lIrq)
);

// File: tb/mbox_slave_port_bench.sv
`timescale 1ns/1ps
module mbox_slave_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mCs = 1'b0, mRd = 1'b0, mWr = 1'b0;
  logic [1:0] mAddr = '0, lAddr = '0;
  logic [7:0] mDataIn = '0, lWdata = '0;
  logic lSel = 1'b0, lWr = 1'b0;
  logic [7:0] mDataOut, lRdata;
  logic mIrq, lIrq;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [7:0] eM2L [3];
  logic [7:0] eL2M [3];
  bit eM2LF = 0, eL2MF = 0;

  always #5 clk = ~clk;

  mbox_slave_port u_mbox_slave_port (
    .clk(clk), .rstN(rstN), .mCs(mCs), .mAddr(mAddr), .mRd(mRd), .mWr(mWr),
    .mDataIn(mDataIn), .mDataOut(mDataOut), .mIrq(mIrq),
    .lSel(lSel), .lWr(lWr), .lAddr(lAddr), .lWdata(lWdata),
    .lRdata(lRdata), .lIrq(lIrq)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] expView(bit toMaster, logic [1:0] a);
    if (a == 2'd3) return {6'b0, eL2MF, eM2LF};
    return toMaster ? eL2M[a] : eM2L[a];
  endfunction

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rstN) begin
      chk("R3/R4 lIrq", {7'b0, lIrq}, {7'b0, eM2LF});
      chk("R5/R6 mIrq", {7'b0, mIrq}, {7'b0, eL2MF});
      chk("R11 mDataOut", mDataOut, expView(1, mAddr));
      chk("R11 lRdata", lRdata, expView(0, lAddr));
    end
  end

  task automatic mWrite(logic [1:0] a, logic [7:0] d, bit cs);
    @(negedge clk);
    mCs = cs; mAddr = a; mDataIn = d; mWr = 1'b1;
    repeat (3) @(posedge clk);
    if (cs && a != 2'd3) eM2L[a] = d;
    if (cs && a == 2'd0) eM2LF = 1;
    repeat (2) @(negedge clk);
    mWr = 1'b0;
    repeat (3) @(negedge clk);
    mCs = 1'b0;
  endtask

  task automatic mRead(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk);
    mCs = 1'b1; mAddr = a; mRd = 1'b1;
    #1 chk(req, mDataOut, exp);
    repeat (3) @(posedge clk);
    if (a == 2'd0) eL2MF = 0;
    repeat (2) @(negedge clk);
    mRd = 1'b0;
    repeat (3) @(negedge clk);
    mCs = 1'b0;
  endtask

  task automatic mPeek(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk);
    mAddr = a;
    #1 chk(req, mDataOut, exp);
  endtask

  task automatic lWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    lSel = 1'b1; lWr = 1'b1; lAddr = a; lWdata = d;
    @(posedge clk);
    if (a != 2'd3) eL2M[a] = d;
    if (a == 2'd0) eL2MF = 1;
    @(negedge clk);
    lSel = 1'b0; lWr = 1'b0;
  endtask

  task automatic lRead(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk);
    lSel = 1'b1; lWr = 1'b0; lAddr = a;
    #1 chk(req, lRdata, exp);
    @(posedge clk);
    if (a == 2'd0) eM2LF = 0;
    @(negedge clk);
    lSel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin eM2L[i] = '0; eL2M[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 lIrq", {7'b0, lIrq}, 8'h00);
    chk("R1 mIrq", {7'b0, mIrq}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      mPeek(2'(i), "R1 master view", 8'h00);
      @(negedge clk); lAddr = 2'(i); #1 chk("R1 local view", lRdata, 8'h00);
    end

    // R2/R7 payload registers from master
    mWrite(2'd1, 8'h5A, 1);
    mWrite(2'd2, 8'hC3, 1);
    chk("R7 no flag from payload", {7'b0, lIrq}, 8'h00);
    lRead(2'd1, "R2 reg1", 8'h5A);
    lRead(2'd2, "R2 reg2", 8'hC3);

    // R3/R4 doorbell master->local
    mWrite(2'd0, 8'h81, 1);
    chk("R3 lIrq set", {7'b0, lIrq}, 8'h01);
    lRead(2'd3, "R8 local status", 8'h01);
    lRead(2'd0, "R2 reg0", 8'h81);
    chk("R4 lIrq cleared", {7'b0, lIrq}, 8'h00);

    // R5/R6/R7 local->master
    lWrite(2'd1, 8'h11);
    lWrite(2'd2, 8'h22);
    chk("R7 mIrq stays low", {7'b0, mIrq}, 8'h00);
    mPeek(2'd1, "R5 reg1", 8'h11);
    lWrite(2'd0, 8'h99);
    chk("R5 mIrq set", {7'b0, mIrq}, 8'h01);
    mPeek(2'd3, "R8 master status", 8'h02);
    mRead(2'd2, "R5 reg2", 8'h22);
    chk("R7 payload read keeps mIrq", {7'b0, mIrq}, 8'h01);
    mRead(2'd0, "R5 reg0", 8'h99);
    chk("R6 mIrq cleared", {7'b0, mIrq}, 8'h00);

    // R8 writes to status ignored
    mWrite(2'd3, 8'hFF, 1);
    lWrite(2'd3, 8'hFF);
    mPeek(2'd3, "R8 status after writes", 8'h00);
    lRead(2'd1, "R8 payload untouched", 8'h5A);

    // R9 deselected strobe ignored
    mWrite(2'd1, 8'h77, 0);
    lRead(2'd1, "R9 cs low ignored", 8'h5A);

    // R9 held strobe acts once
    @(negedge clk);
    mCs = 1'b1; mAddr = 2'd0; mDataIn = 8'h3C; mWr = 1'b1;
    repeat (3) @(posedge clk);
    eM2L[0] = 8'h3C; eM2LF = 1;
    lRead(2'd0, "R9 held data", 8'h3C);
    repeat (6) @(negedge clk);
    chk("R9 held strobe no second event", {7'b0, lIrq}, 8'h00);
    mWr = 1'b0;
    repeat (3) @(negedge clk);
    mCs = 1'b0;

    // R10 same-edge set and clear
    @(negedge clk);
    mCs = 1'b1; mAddr = 2'd0; mDataIn = 8'hA5; mWr = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    lSel = 1'b1; lWr = 1'b0; lAddr = 2'd0;
    @(posedge clk);
    eM2L[0] = 8'hA5; eM2LF = 1;
    @(negedge clk);
    lSel = 1'b0; mWr = 1'b0;
    chk("R10 set wins", {7'b0, lIrq}, 8'h01);
    repeat (3) @(negedge clk);
    mCs = 1'b0;
    lRead(2'd0, "R10 new byte kept", 8'hA5);

    // Both directions full at once
    mWrite(2'd0, 8'h42, 1);
    lWrite(2'd0, 8'h24);
    mPeek(2'd3, "R8 both full master", 8'h03);
    lRead(2'd3, "R8 both full local", 8'h03);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule